// File: doc/BRIEF.md
# Scanning ADC Sequencer with Tagged Sample FIFO

This block sits in front of a multiplexed analog-to-digital converter. It walks a window of input channels held in one scan register, presents each channel's stored gain code and input-mode bit to the analog front end, and starts a conversion whenever an enabled trigger source fires. The sources are a software strobe, an internal pacer pulse that can be gated, and an external trigger pulse. The converter is modelled as a stub with a fixed latency. When a conversion ends, the result is stamped with its channel number and pushed into a sample FIFO.

A host uses a small 16-bit register bus. It programs control, scan window and gain codes. It reads a status word and pops tagged samples. An interrupt can be raised for each stored sample, or once when the FIFO fills to half its depth. The pending flag is cleared by a write to its own offset, and the FIFO is emptied by a write to another offset.

Top module: `scan_adc_seq`

## Requirements
- R1: After reset the control word is 0, the FIFO is empty, the status word (offset 6) reads 0x0100 and `irq` is low.
- R2: Each word popped from offset 0 is {channel[3:0], result[11:0]}. The result is `adc_result` as sampled on the cycle the conversion completes, CONV_LAT clocks after the trigger.
- R3: The scan register (offset 4) holds the first channel in bits 3:0 and the last channel in bits 11:8. Writing it restarts the scan at the first channel. Successive conversions advance through the window, and the channel after the last one is the first one.
- R4: A write to offset 2 stores gain bits 2:0 and input-mode bit 5 for the channel in the first-channel field. While that channel converts, `gain_sel` shows the stored gain code.
- R5: A conversion starts only from an enabled source. The sources are a write to offset 0 with control bit 0 set, `pacer_tick` with control bit 1 set, and `ext_trig` with control bit 2 set. With control bit 3 set, pacer pulses count only while `ext_gate` is high. Triggers that arrive while a conversion is running are ignored.
- R6: Mode bit 5 set marks a channel as differential, and `diff_sel` is high while it converts. A differential channel advances the scan by two instead of one. A mode write aimed at an odd channel is stored as single-ended.
- R7: Status bits: 8 = FIFO empty, 9 = at least DEPTH/2 samples held, 10 = full or has been full, 11 = interrupt pending. Bits 6:0 read back the control word.
- R8: When the FIFO holds DEPTH samples, new samples are dropped. Status bit 10 stays set until the FIFO is cleared, even after reads.
- R9: A read of offset 0 while the FIFO is empty returns the word popped last and removes nothing.
- R10: With control bit 5 clear, every stored sample sets the pending flag. With bit 5 set, the pending flag is set only when the fill level reaches DEPTH/2. Any write to offset 8 clears the flag. `irq` equals control bit 4 AND the pending flag.
- R11: Any write to offset 9 empties the FIFO and clears the full indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at offset 0) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset |
| pacer_tick | input | 1 | Internal pacer pulse |
| ext_trig | input | 1 | External trigger pulse |
| ext_gate | input | 1 | Pacer gate level |
| adc_result | input | 12 | Converter result, sampled at conversion end |
| mux_chan | output | 4 | Channel being converted |
| gain_sel | output | 3 | Gain code of that channel |
| diff_sel | output | 1 | Differential mode of that channel |
| conv_active | output | 1 | Conversion in progress |
| pacer_clk_ext | output | 1 | Counter clock source select (control bit 6) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. Trigger inputs are single-cycle pulses synchronous to `clk`. A read and a write never share a cycle. `adc_result` holds steady while a conversion runs. The bench drives every input on the falling edge and sets `adc_result` before it issues a trigger. It waits the full conversion latency before the next trigger, except in the one directed case that fires a second trigger into a busy converter. Random scan windows, mode bits and sample values are checked against a queue-based model of the FIFO and the scan order.

// File: rtl/scan_adc_seq.sv
module scan_adc_seq #(
  parameter int DEPTH    = 1024,
  parameter int CONV_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        pacer_tick,
  input  logic        ext_trig,
  input  logic        ext_gate,
  input  logic [11:0] adc_result,
  output logic [3:0]  mux_chan,
  output logic [2:0]  gain_sel,
  output logic        diff_sel,
  output logic        conv_active,
  output logic        pacer_clk_ext,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(CONV_LAT) + 1;
  localparam logic [AW:0] FULLC = DEPTH;
  localparam logic [AW:0] HALFC = DEPTH / 2;
  localparam logic [LW-1:0] LAT_M1 = LW'(CONV_LAT - 1);

  logic [6:0]    ctrl;
  logic [3:0]    first_ch, last_ch, cur_ch, conv_ch;
  logic [3:0]    gain_ram [16];
  logic          busy, pend, ovf;
  logic [LW-1:0] lat_cnt;
  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic [15:0]   last_word;
  logic          unused_bits;

  assign unused_bits = ^{bus_wdata[15:12], bus_wdata[7:6], bus_wdata[4:3]};

  wire wr_data  = bus_wr && bus_addr == 4'd0;
  wire wr_gain  = bus_wr && bus_addr == 4'd2;
  wire wr_scan  = bus_wr && bus_addr == 4'd4;
  wire wr_ctrl  = bus_wr && bus_addr == 4'd6;
  wire wr_ack   = bus_wr && bus_addr == 4'd8;
  wire clr      = bus_wr && bus_addr == 4'd9;
  wire empty    = count == '0;
  wire full_now = count == FULLC;
  wire pop      = bus_rd && bus_addr == 4'd0 && !empty;

  wire trig = (wr_data && ctrl[0]) ||
              (pacer_tick && ctrl[1] && (!ctrl[3] || ext_gate)) ||
              (ext_trig && ctrl[2]);
  wire start = trig && !busy;
  wire push  = busy && lat_cnt == '0;
  wire wr_ok = push && !full_now;
  wire [AW:0] cnt_next = count + (wr_ok ? 1 : 0) - (pop ? 1 : 0);
  wire half_hit = wr_ok && !pop && count == HALFC - 1;
  wire pend_set = ctrl[5] ? half_hit : wr_ok;

  wire [4:0] step_ch = {1'b0, cur_ch} + (gain_ram[cur_ch][3] ? 5'd2 : 5'd1);
  wire [3:0] next_ch = (cur_ch == last_ch || step_ch > {1'b0, last_ch}) ? first_ch : step_ch[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; first_ch <= '0; last_ch <= '0; cur_ch <= '0;
      conv_ch <= '0; busy <= 1'b0; lat_cnt <= '0; pend <= 1'b0;
      for (int i = 0; i < 16; i++) gain_ram[i] <= '0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[6:0];
      if (wr_gain) gain_ram[first_ch] <= {bus_wdata[5] & ~first_ch[0], bus_wdata[2:0]};
      if (wr_scan) begin
        first_ch <= bus_wdata[3:0];
        last_ch  <= bus_wdata[11:8];
        cur_ch   <= bus_wdata[3:0];
      end else if (start) begin
        cur_ch <= next_ch;
      end
      if (start) begin
        busy <= 1'b1; lat_cnt <= LAT_M1; conv_ch <= cur_ch;
      end else if (push) begin
        busy <= 1'b0;
      end else if (busy) begin
        lat_cnt <= lat_cnt - 1'b1;
      end
      if (pend_set) pend <= 1'b1;
      else if (wr_ack) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0; rptr <= '0; count <= '0; ovf <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (pop) rptr <= rptr + 1'b1;
      count <= cnt_next;
      if (full_now) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_word <= '0;
    else if (pop) last_word <= mem[rptr];
  end

  always_ff @(posedge clk)
    if (wr_ok) mem[wptr] <= {conv_ch, adc_result};

  always_comb begin
    case (bus_addr)
      4'd0:    bus_rdata = empty ? last_word : mem[rptr];
      4'd6:    bus_rdata = {4'b0, pend, ovf | full_now, count >= HALFC, empty, 1'b0, ctrl};
      default: bus_rdata = '0;
    endcase
  end

  assign mux_chan      = conv_ch;
  assign gain_sel      = gain_ram[conv_ch][2:0];
  assign diff_sel      = gain_ram[conv_ch][3];
  assign conv_active   = busy;
  assign pacer_clk_ext = ctrl[6];
  assign irq           = ctrl[4] & pend;

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd0 && empty && !clr) |=> $stable(rptr) && $stable(last_word));
  assert_irq_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !pend_set) |=> !irq);
  assert_odd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && mux_chan[0]) |-> !diff_sel);
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat_cnt != '0) |=> $stable(conv_ch) && busy);
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bus_addr != 4'd6 || bus_rdata[10:8] == 3'b001 || bus_rdata[8] == 1'b0 || bus_rdata[10] == 1'b0));
endmodule

// File: tb/scan_adc_seq_tb.sv
module scan_adc_seq_tb_top;
  localparam int DEPTH = 16;
  localparam int LAT = 3;
  localparam int HALF = DEPTH / 2;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic pacer_tick = 0, ext_trig = 0, ext_gate = 0;
  logic [11:0] adc_result = 0;
  logic [3:0] mux_chan;
  logic [2:0] gain_sel;
  logic diff_sel, conv_active, pacer_clk_ext, irq;

  scan_adc_seq #(.DEPTH(DEPTH), .CONV_LAT(LAT)) dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] q[$];
  logic [3:0] mfirst = 0, mlast = 0, mcur = 0;
  logic mdiff [16];
  logic [6:0] mctrl = 0;
  logic mpend = 0, mfull = 0;
  logic [15:0] mlast_word = 0;
  logic [3:0] obs_ch;
  logic [2:0] obs_gain;
  logic obs_diff;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt(input logic [3:0] c);
    logic [4:0] s = {1'b0, c} + (mdiff[c] ? 5'd2 : 5'd1);
    return (c == mlast || s > {1'b0, mlast}) ? mfirst : s[3:0];
  endfunction

  function automatic logic [15:0] exp_status();
    return {4'b0, mpend, mfull, q.size() >= HALF, q.size() == 0, 1'b0, mctrl};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    if (a == 4'd6) mctrl = d[6:0];
    if (a == 4'd8) mpend = 0;
    if (a == 4'd9) begin q.delete(); mfull = 0; end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic model_conv(input logic [11:0] v);
    if (q.size() < DEPTH) begin
      q.push_back({mcur, v});
      if (!mctrl[5]) mpend = 1;
      else if (q.size() == HALF) mpend = 1;
    end
    if (q.size() == DEPTH) mfull = 1;
    mcur = nxt(mcur);
  endtask

  task automatic sconv(input logic [11:0] v);
    adc_result = v;
    wr(4'd0, 16'h0);
    obs_ch = mux_chan; obs_gain = gain_sel; obs_diff = diff_sel;
    model_conv(v);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic setscan(input logic [3:0] f, input logic [3:0] l);
    wr(4'd4, {4'b0, l, 4'b0, f});
    mfirst = f; mlast = l; mcur = f;
  endtask

  task automatic setgain(input logic [2:0] g, input logic d);
    wr(4'd2, {10'b0, d, 2'b0, g});
    mdiff[mfirst] = d & ~mfirst[0];
  endtask

  task automatic chk_status(input string req);
    logic [15:0] s;
    rd(4'd6, s);
    check(req, s, exp_status());
    check(req, {15'b0, irq}, {15'b0, mctrl[4] & mpend});
  endtask

  task automatic drain(input string req);
    logic [15:0] w;
    while (q.size() > 0) begin
      rd(4'd0, w);
      check(req, w, q[0]);
      mlast_word = q.pop_front();
    end
  endtask

  task automatic pulse(input int which);
    if (which == 0) pacer_tick = 1; else ext_trig = 1;
    @(negedge clk);
    pacer_tick = 0; ext_trig = 0;
    repeat (LAT + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(1234));
    for (int i = 0; i < 16; i++) mdiff[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'd6, w);
    check("R1 reset status", w, 16'h0100);
    check("R1 reset irq", {15'b0, irq}, 16'h0);

    wr(4'd6, 16'h0001);
    setscan(4'd3, 4'd3); setgain(3'd5, 1'b0);
    sconv(12'hA5C);
    check("R4 gain on mux", {13'b0, obs_gain}, 16'h5);
    check("R4 channel on mux", {12'b0, obs_ch}, 16'h3);
    drain("R2 tagged word");

    setscan(4'd2, 4'd5);
    for (int i = 0; i < 6; i++) sconv(12'($urandom));
    chk_status("R7 status after scan");
    drain("R3 scan order with wrap");

    pulse(0); chk_status("R5 pacer disabled");
    pulse(1); chk_status("R5 external disabled");
    wr(4'd6, 16'h0002);
    adc_result = 12'h111; model_conv(12'h111); pulse(0);
    chk_status("R5 pacer enabled");
    wr(4'd6, 16'h0004);
    adc_result = 12'h222; model_conv(12'h222); pulse(1);
    wr(4'd6, 16'h000A);
    ext_gate = 0; pulse(0); chk_status("R5 gate closed");
    ext_gate = 1; adc_result = 12'h333; model_conv(12'h333); pulse(0);
    ext_gate = 0;
    wr(4'd6, 16'h0001);
    adc_result = 12'h444;
    wr(4'd0, 16'h0); model_conv(12'h444);
    wr(4'd0, 16'h0);
    repeat (LAT + 1) @(negedge clk);
    chk_status("R5 trigger while busy ignored");
    drain("R5 triggered samples");

    setscan(4'd5, 4'd5); setgain(3'd2, 1'b1);
    sconv(12'h055);
    check("R6 odd channel stays single-ended", {15'b0, obs_diff}, 16'h0);
    setscan(4'd4, 4'd4); setgain(3'd1, 1'b1);
    sconv(12'h044);
    check("R6 even channel differential", {15'b0, obs_diff}, 16'h1);
    setscan(4'd4, 4'd7);
    for (int i = 0; i < 5; i++) sconv(12'($urandom));
    drain("R6 differential step");

    wr(4'd6, 16'h0011); wr(4'd8, 0);
    chk_status("R10 no pending");
    sconv(12'h0F0);
    check("R10 per-sample irq", {15'b0, irq}, 16'h1);
    wr(4'd6, 16'h0001);
    chk_status("R10 irq masked while pending");
    wr(4'd8, 0);
    chk_status("R10 ack clears pending");
    wr(4'd9, 0);
    chk_status("R11 clear empties fifo");

    wr(4'd6, 16'h0031);
    for (int i = 0; i < HALF - 1; i++) sconv(12'($urandom));
    check("R10 below half no irq", {15'b0, irq}, 16'h0);
    sconv(12'h777);
    check("R10 half-full irq", {15'b0, irq}, 16'h1);
    chk_status("R7 half flag");
    wr(4'd8, 0);
    for (int i = 0; i < HALF + 2; i++) sconv(12'($urandom));
    chk_status("R8 full and dropped");
    rd(4'd0, w); check("R8 oldest kept", w, q[0]); mlast_word = q.pop_front();
    chk_status("R8 full sticky after read");
    drain("R8 contents after overflow");
    rd(4'd0, w); check("R9 empty read last word", w, mlast_word);
    rd(4'd0, w); check("R9 empty read repeat", w, mlast_word);
    chk_status("R9 still empty");
    wr(4'd9, 0);
    chk_status("R11 clear resets full");

    wr(4'd6, 16'h0001);
    for (int it = 0; it < 30; it++) begin
      logic [3:0] f = 4'($urandom), l = 4'($urandom);
      if (f > l) begin logic [3:0] t = f; f = l; l = t; end
      setscan(f, f); setgain(3'($urandom), 1'($urandom));
      setscan(f, l);
      for (int k = 0; k < 1 + $urandom % 6; k++) sconv(12'($urandom));
      chk_status("R7 random status");
      drain("R3 random scan words");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule